// File: doc/BRIEF.md
# Event-Buffered Reactive Controller

This block is a clocked reactive state machine that receives events from neighbouring machines through single-place buffers, with one buffer per input signal. A sender emits an event by pulsing its valid line while it drives a data value. The buffer then holds a presence flag and the data until the machine consumes them. Writes never stall. A fresh emission into a buffer that still holds an event replaces it, and a one-cycle loss pulse reports the replacement.

Each reaction runs a fixed sequence of phases. The machine waits in idle until an event is present, or until the single reaction that follows reset. It then captures every presence flag into one snapshot. Next it looks up the snapshot and the current state in a small rule table, performs at most one transition, and finally raises the output events whose data lanes it has already written. A matched rule consumes every event in the snapshot. An unmatched lookup changes nothing.

Top module: `evbuf_reactor`

## Requirements
- R1: Each input signal has exactly one buffer. A pulse on `inValid[i]` marks buffer i present (`pending[i]`=1 from the next cycle) and stores `inData[i*DATA_W +: DATA_W]`.
- R2: A matched transition clears every buffer whose flag is in the snapshot, including flags that the rule did not need.
- R3: Writes never block. A second emission into a present buffer replaces its data, and the buffer stays present.
- R4: The phases run idle, detect, execute, emit, one cycle each and never overlapping. For an emission sampled at clock edge E0 on an idle machine, the output valid is high only in the cycle after edge E4.
- R5: The flags are captured into one snapshot during detect. An event that lands after the capture plays no part in that reaction and stays pending for the next one.
- R6: An output data lane is written in the execute cycle, at least one cycle before its valid pulse, and it does not change while the valid is high. Input data is read in execute, one cycle after its flag was captured.
- R7: Apart from the reaction that follows reset, a reaction starts only when at least one buffer is present. With no events the state does not change and no output fires.
- R8: During reset, `stateOut` is 0, all buffers are absent and no output is valid. The first reaction after reset moves the state to 1 without any event, consumes nothing and emits nothing.
- R9: When no rule matches, no buffer is consumed, the state is kept and no output fires.
- R10: A trivial transition (state 3 with input 0) keeps the state and emits nothing, yet it still consumes its inputs.
- R11: `lost[i]` pulses for one cycle, one cycle after an emission on input i lands on a buffer that is still present and is not being consumed on that edge.
- R12: When an emission and a consume hit the same buffer on the same edge, the emission wins: the buffer stays present with the new data and `lost` stays low.
- R13: The rules are checked in priority order, lowest first. The input needs are the AND of the listed events.
  - State 1 needing input 0 goes to state 2 and emits output 0 with the data of input 0.
  - State 2 needing inputs 1 and 2 goes to state 1 and emits outputs 0 and 1 with the data of input 2.
  - State 2 needing input 1 goes to state 3 and emits output 1 with the data of input 1.
  - State 3 needing input 2 goes to state 1 and emits nothing.
  - State 3 needing input 0 stays in state 3 and emits nothing.
  - Output k uses `outData[k*DATA_W +: DATA_W]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | NUM_IN | One-cycle emission strobe per input signal |
| inData | input | NUM_IN*DATA_W | Data lane per input, sampled with its strobe |
| pending | output | NUM_IN | Presence flag of each input buffer |
| lost | output | NUM_IN | One-cycle pulse when an emission replaced an unconsumed event |
| outValid | output | NUM_OUT | Output event pulses |
| outData | output | NUM_OUT*DATA_W | Output data lanes, held until rewritten |
| stateOut | output | STATE_W | Current machine state |

## Verification
The assertions place no condition on when senders emit: a strobe may arrive in any phase, including on the same edge as a consume. They do assume that a strobe lasts one cycle for each event, because a held strobe counts as one emission per cycle and would show up as losses. The stimulus therefore drives every emission as a single-cycle pulse on the falling edge. To hit the capture and consume edges on purpose, it places a second pulse exactly three edges after the first.

// File: rtl/evbuf_pkg.sv
package evbuf_pkg;
  localparam int NUM_IN     = 3;
  localparam int NUM_OUT    = 2;
  localparam int STATE_W    = 2;
  localparam int NUM_RULES  = 5;
  localparam int SEL_W      = $clog2(NUM_IN);
  localparam int RULE_IDX_W = $clog2(NUM_RULES);
  localparam logic [STATE_W-1:0] INIT_STATE = STATE_W'(1);

  typedef enum logic [1:0] {PH_IDLE, PH_DETECT, PH_EXEC, PH_EMIT} phase_t;

  typedef struct packed {
    logic [STATE_W-1:0] fromState;
    logic [NUM_IN-1:0]  need;
    logic [STATE_W-1:0] toState;
    logic [NUM_OUT-1:0] emit;
    logic [SEL_W-1:0]   dataSrc;
  } rule_t;

  // Priority order: lowest index wins.
  localparam rule_t RULES [NUM_RULES] = '{
    '{2'd1, 3'b001, 2'd2, 2'b01, 2'd0},
    '{2'd2, 3'b110, 2'd1, 2'b11, 2'd2},
    '{2'd2, 3'b010, 2'd3, 2'b10, 2'd1},
    '{2'd3, 3'b100, 2'd1, 2'b00, 2'd0},
    '{2'd3, 3'b001, 2'd3, 2'b00, 2'd0}
  };

  // Strobes from control to datapath.
  typedef struct packed {
    logic               capture;
    logic [NUM_IN-1:0]  consume;
    logic [NUM_OUT-1:0] load;
    logic [SEL_W-1:0]   dataSel;
    logic [NUM_OUT-1:0] fire;
  } strobe_t;
endpackage

// File: rtl/evbuf_ctrl.sv
module evbuf_ctrl
  import evbuf_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               pendingAny,
  input  logic [NUM_IN-1:0]  snap,
  output logic [STATE_W-1:0] stateOut,
  output strobe_t            st
);
  phase_t phase;
  logic [STATE_W-1:0] state;
  logic initDone;
  logic [NUM_OUT-1:0] fireMask;
  logic hit;
  logic [RULE_IDX_W-1:0] ruleIdx;

  // Rule lookup: scan high to low so the lowest matching index is kept.
  always_comb begin
    hit = 1'b0;
    ruleIdx = '0;
    for (int r = NUM_RULES - 1; r >= 0; r--) begin
      if (RULES[r].fromState == state && (snap & RULES[r].need) == RULES[r].need) begin
        hit = 1'b1;
        ruleIdx = RULE_IDX_W'(r);
      end
    end
  end

  logic takeRule;
  assign takeRule = (phase == PH_EXEC) && initDone && hit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase    <= PH_IDLE;
      state    <= '0;
      initDone <= 1'b0;
      fireMask <= '0;
    end else begin
      case (phase)
        PH_IDLE:   if (!initDone || pendingAny) phase <= PH_DETECT;
        PH_DETECT: phase <= PH_EXEC;
        PH_EXEC: begin
          phase <= PH_EMIT;
          if (!initDone) begin
            state    <= INIT_STATE;
            initDone <= 1'b1;
            fireMask <= '0;
          end else if (hit) begin
            state    <= RULES[ruleIdx].toState;
            fireMask <= RULES[ruleIdx].emit;
          end else begin
            fireMask <= '0;
          end
        end
        default:   phase <= PH_IDLE;
      endcase
    end
  end

  always_comb begin
    st.capture = (phase == PH_DETECT);
    st.consume = takeRule ? snap : '0;
    st.load    = takeRule ? RULES[ruleIdx].emit : '0;
    st.dataSel = RULES[ruleIdx].dataSrc;
    st.fire    = (phase == PH_EMIT) ? fireMask : '0;
  end

  assign stateOut = state;

  p_detect_to_exec_r4: assert property (@(posedge clk) disable iff (!rstN)
    phase == PH_DETECT |=> phase == PH_EXEC);
  p_exec_to_emit_r4: assert property (@(posedge clk) disable iff (!rstN)
    phase == PH_EXEC |=> phase == PH_EMIT);
  p_emit_to_idle_r4: assert property (@(posedge clk) disable iff (!rstN)
    phase == PH_EMIT |=> phase == PH_IDLE);
  p_quiet_stays_idle_r7: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_IDLE && initDone && !pendingAny) |=> phase == PH_IDLE);
  p_init_reaction_r8: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_EXEC && !initDone) |=> (state == INIT_STATE && fireMask == '0));
  p_nomatch_holds_r9: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_EXEC && initDone && !hit) |=> (state == $past(state) && fireMask == '0));
endmodule

// File: rtl/evbuf_dpath.sv
module evbuf_dpath
  import evbuf_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [NUM_IN-1:0]         inValid,
  input  logic [NUM_IN*DATA_W-1:0]  inData,
  input  strobe_t                   st,
  output logic [NUM_IN-1:0]         pending,
  output logic                      pendingAny,
  output logic [NUM_IN-1:0]         snap,
  output logic [NUM_IN-1:0]         lost,
  output logic [NUM_OUT-1:0]        outValid,
  output logic [NUM_OUT*DATA_W-1:0] outData
);
  logic [NUM_IN*DATA_W-1:0] bufData;
  logic [DATA_W-1:0] selData;

  for (genvar i = 0; i < NUM_IN; i++) begin : g_buf
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        pending[i] <= 1'b0;
        lost[i]    <= 1'b0;
        bufData[i*DATA_W +: DATA_W] <= '0;
      end else begin
        if (inValid[i]) begin
          pending[i] <= 1'b1;
          bufData[i*DATA_W +: DATA_W] <= inData[i*DATA_W +: DATA_W];
        end else if (st.consume[i]) begin
          pending[i] <= 1'b0;
        end
        lost[i] <= inValid[i] & pending[i] & ~st.consume[i];
      end
    end

    p_consume_clears_r2: assert property (@(posedge clk) disable iff (!rstN)
      (st.consume[i] && !inValid[i]) |=> !pending[i]);
    p_emit_wins_r12: assert property (@(posedge clk) disable iff (!rstN)
      (st.consume[i] && inValid[i]) |=> (pending[i] && !lost[i]));
    p_lost_means_present_r11: assert property (@(posedge clk) disable iff (!rstN)
      lost[i] |-> pending[i]);
  end

  assign pendingAny = |pending;

  // Data is read in execute, a cycle after the flag was captured.
  always_comb begin
    selData = '0;
    for (int i = 0; i < NUM_IN; i++)
      if (st.dataSel == SEL_W'(i)) selData = bufData[i*DATA_W +: DATA_W];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) snap <= '0;
    else if (st.capture) snap <= pending;
  end

  for (genvar k = 0; k < NUM_OUT; k++) begin : g_out
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) outData[k*DATA_W +: DATA_W] <= '0;
      else if (st.load[k]) outData[k*DATA_W +: DATA_W] <= selData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) outValid <= '0;
    else outValid <= st.fire;
  end

  p_snapshot_frozen_r5: assert property (@(posedge clk) disable iff (!rstN)
    !st.capture |=> $stable(snap));
  p_data_before_event_r6: assert property (@(posedge clk) disable iff (!rstN)
    (|outValid) |-> $stable(outData));
endmodule

// File: rtl/evbuf_reactor.sv
module evbuf_reactor
  import evbuf_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [NUM_IN-1:0]         inValid,
  input  logic [NUM_IN*DATA_W-1:0]  inData,
  output logic [NUM_IN-1:0]         pending,
  output logic [NUM_IN-1:0]         lost,
  output logic [NUM_OUT-1:0]        outValid,
  output logic [NUM_OUT*DATA_W-1:0] outData,
  output logic [STATE_W-1:0]        stateOut
);
  strobe_t st;
  logic pendingAny;
  logic [NUM_IN-1:0] snap;

  evbuf_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .pendingAny(pendingAny), .snap(snap),
    .stateOut(stateOut), .st(st)
  );

  evbuf_dpath #(.DATA_W(DATA_W)) u_dpath (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inData(inData), .st(st),
    .pending(pending), .pendingAny(pendingAny), .snap(snap), .lost(lost),
    .outValid(outValid), .outData(outData)
  );
endmodule

// File: tb/evbuf_reactor_test.sv
module evbuf_reactor_test;
  import evbuf_pkg::*;
  localparam int DW = 8;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rstN;
  logic [NUM_IN-1:0] inValid;
  logic [NUM_IN*DW-1:0] inData;
  logic [NUM_IN-1:0] pending, lost;
  logic [NUM_OUT-1:0] outValid;
  logic [NUM_OUT*DW-1:0] outData;
  logic [STATE_W-1:0] stateOut;

  evbuf_reactor #(.DATA_W(DW)) uut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inData(inData),
    .pending(pending), .lost(lost), .outValid(outValid), .outData(outData),
    .stateOut(stateOut)
  );

  int nChecks = 0;
  int nFail = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Monitor, sampling one time unit after each rising edge.
  logic [NUM_OUT-1:0] seenMask = '0;
  logic [NUM_IN-1:0]  seenLost = '0;
  logic [DW-1:0]      seenData [NUM_OUT];
  always @(posedge clk) begin
    #1;
    seenMask = seenMask | outValid;
    seenLost = seenLost | lost;
    for (int k = 0; k < NUM_OUT; k++)
      if (outValid[k]) seenData[k] = outData[k*DW +: DW];
  end

  task automatic clearSeen();
    seenMask = '0;
    seenLost = '0;
    for (int k = 0; k < NUM_OUT; k++) seenData[k] = '0;
  endtask

  task automatic pulse(input logic [NUM_IN-1:0] m, input logic [DW-1:0] d0,
                       input logic [DW-1:0] d1, input logic [DW-1:0] d2);
    inValid = m;
    inData  = {d2, d1, d0};
    @(negedge clk);
    inValid = '0;
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  typedef struct packed {
    logic [NUM_IN-1:0]  mask;
    logic [DW-1:0]      d0, d1, d2;
    logic [STATE_W-1:0] expState;
    logic [NUM_IN-1:0]  expPend;
    logic [NUM_OUT-1:0] expOut;
    logic [DW-1:0]      expData;
  } vec_t;

  localparam vec_t VECS [7] = '{
    '{3'b010, 8'h00, 8'h31, 8'h00, 2'd1, 3'b010, 2'b00, 8'h00}, // R9 unmatched in state 1
    '{3'b001, 8'h40, 8'h00, 8'h00, 2'd2, 3'b000, 2'b01, 8'h40}, // R2 clears unneeded input 1
    '{3'b110, 8'h00, 8'h12, 8'h34, 2'd1, 3'b000, 2'b11, 8'h34}, // R13 priority of both-input rule
    '{3'b001, 8'h07, 8'h00, 8'h00, 2'd2, 3'b000, 2'b01, 8'h07}, // R13
    '{3'b010, 8'h00, 8'h99, 8'h00, 2'd3, 3'b000, 2'b10, 8'h99}, // R13
    '{3'b001, 8'h55, 8'h00, 8'h00, 2'd3, 3'b000, 2'b00, 8'h00}, // R10 trivial discards
    '{3'b100, 8'h00, 8'h00, 8'h66, 2'd1, 3'b000, 2'b00, 8'h00}  // R13
  };

  task automatic summary();
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
  endtask

  initial begin
    #400000;
    nChecks++;
    nFail++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    rstN = 1'b0;
    inValid = '0;
    inData = '0;
    clearSeen();
    settle(3);
    // R8 reset state
    check(stateOut == 0, "R8 reset state", int'(stateOut), 0);
    check(pending == 0 && outValid == 0, "R8 reset buffers/outputs", int'({pending, outValid}), 0);
    rstN = 1'b1;
    settle(12);
    check(stateOut == 1, "R8 initial reaction", int'(stateOut), 1);
    check(seenMask == 0, "R8 initial reaction emits nothing", int'(seenMask), 0);
    settle(20);
    check(stateOut == 1 && seenMask == 0, "R7 no event no reaction", int'({seenMask, stateOut}), 1);

    // Vector table
    foreach (VECS[v]) begin
      clearSeen();
      pulse(VECS[v].mask, VECS[v].d0, VECS[v].d1, VECS[v].d2);
      settle(12);
      check(stateOut == VECS[v].expState, $sformatf("R13 vec%0d state", v), int'(stateOut), int'(VECS[v].expState));
      check(pending == VECS[v].expPend, $sformatf("R1 R2 R9 vec%0d pending", v), int'(pending), int'(VECS[v].expPend));
      check(seenMask == VECS[v].expOut, $sformatf("R9 R10 vec%0d outputs", v), int'(seenMask), int'(VECS[v].expOut));
      for (int k = 0; k < NUM_OUT; k++)
        if (VECS[v].expOut[k])
          check(seenData[k] == VECS[v].expData, $sformatf("R13 vec%0d lane%0d data", v, k), int'(seenData[k]), int'(VECS[v].expData));
    end

    // R4 / R6 reaction timing, state 1 -> 2
    clearSeen();
    pulse(3'b001, 8'hC3, 8'h00, 8'h00);
    settle(3);
    check(outValid == 0, "R4 no output before edge E4", int'(outValid), 0);
    check(outData[0 +: DW] == 8'hC3, "R6 data written before event", int'(outData[0 +: DW]), 'hC3);
    settle(1);
    check(outValid == 2'b01, "R4 output after edge E4", int'(outValid), 1);
    settle(1);
    check(outValid == 0, "R4 output lasts one cycle", int'(outValid), 0);

    // R3 / R11 overwrite in state 2 (input 2 alone is unmatched)
    pulse(3'b100, 8'h00, 8'h00, 8'h01);
    settle(12);
    clearSeen();
    pulse(3'b100, 8'h00, 8'h00, 8'h02);
    settle(4);
    check(seenLost == 3'b100, "R11 loss pulse on overwrite", int'(seenLost), 4);
    check(pending == 3'b100 && stateOut == 2, "R3 buffer stays present", int'({pending, stateOut}), 'h12);
    clearSeen();
    pulse(3'b010, 8'h00, 8'h77, 8'h00);
    settle(12);
    check(seenMask == 2'b11 && seenData[0] == 8'h02, "R3 newer data used", int'(seenData[0]), 2);
    check(seenLost == 0 && stateOut == 1 && pending == 0, "R2 state1 after both-input rule", int'({seenLost, pending, stateOut}), 1);

    // R5 snapshot atomicity: input 2 lands after capture
    pulse(3'b001, 8'h01, 8'h00, 8'h00);
    settle(12);
    clearSeen();
    pulse(3'b010, 8'h00, 8'h21, 8'h00);
    settle(2);
    pulse(3'b100, 8'h00, 8'h00, 8'h43);
    settle(12);
    check(seenMask == 2'b10, "R5 late event ignored in reaction", int'(seenMask), 2);
    check(seenData[1] == 8'h21, "R5 data of captured event", int'(seenData[1]), 'h21);
    check(stateOut == 1 && pending == 0, "R5 late event handled next", int'({pending, stateOut}), 1);

    // R12 emission and consume on the same edge
    pulse(3'b001, 8'h01, 8'h00, 8'h00);
    settle(12);
    clearSeen();
    pulse(3'b010, 8'h00, 8'h11, 8'h00);
    settle(2);
    pulse(3'b010, 8'h00, 8'h22, 8'h00);
    settle(12);
    check(pending == 3'b010, "R12 emission wins over consume", int'(pending), 2);
    check(seenLost == 0, "R12 no loss pulse", int'(seenLost), 0);
    check(stateOut == 3 && seenData[1] == 8'h11, "R6 data read at execute", int'(seenData[1]), 'h11);
    clearSeen();
    pulse(3'b100, 8'h00, 8'h00, 8'h00);
    settle(12);
    check(stateOut == 1 && pending == 0 && seenMask == 0, "R2 R9 cleanup from state3",
          int'({seenMask, pending, stateOut}), 1);

    summary();
    $finish;
  end
endmodule